// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the host-facing side of an embedded controller. A host on a small byte-wide I/O bus sees three locations: a data port, a combined status/command port, and an interrupt control byte. The host drives the controller one byte at a time. It writes a command code to the command port and then writes the operand bytes, an address and sometimes a value, to the data port. Two flags in the status byte pace the exchange. The input-full flag tells the host that the controller has not yet taken the last byte. The output-full flag tells the host that a result is waiting in the data port.

Inside the block, a busy timer stands in for the controller's firmware latency. Each byte is held for a fixed number of clock cycles before a sequencer acts on it. The sequencer turns completed read and write sequences into single-cycle accesses on a 256-entry register-space port, which is brought out of the block. It loads read results and query answers into an output buffer. A read command takes one address byte and returns the value stored at that address. A write command takes an address byte and then a data byte. The burst-enable and burst-disable codes only set and clear a status bit. The query code returns a fixed, parameter-chosen byte.

Top module: `ec_host_port`

## Requirements
- R1: After reset, the status byte (offset 0x04) and the interrupt control byte (offset 0x08) read 0x00, and no register-space write occurs.
- R2: A host write to offset 0x00 or 0x04 sets input-full (status bit 1) from the next cycle. The flag stays set for exactly BUSY_CYCLES cycles and then clears by itself.
- R3: Status bit 3 is set by a host write to offset 0x04 and cleared by a host write to offset 0x00.
- R4: The read sequence is command 0x80 followed by one address byte at 0x00. When the controller takes the address byte, the data port holds the register-space value at that address and output-full (status bit 0) is set in the same cycle that input-full clears.
- R5: The write sequence is command 0x81, then an address byte, then a data byte. It produces exactly one register-space write with that address and data, in the cycle that the data byte is consumed.
- R6: A host read of offset 0x00 clears output-full. Reading offset 0x04 leaves output-full unchanged.
- R7: Command 0x82 sets status bit 4 and command 0x83 clears it. Neither command touches the register space or output-full.
- R8: Command 0x84 loads QUERY_VALUE into the data port and sets output-full.
- R9: A command byte that arrives in the middle of a read or write sequence abandons that sequence without any register-space access and starts the new one.
- R10: A data byte that arrives outside a sequence is ignored, and so are an unknown command code and the bytes that follow it. No register-space write occurs and output-full does not change.
- R11: The byte at offset 0x08 can be written and read back. Writing it neither sets input-full nor changes status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one cycle per byte |
| bus_re | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | OFS_W | Host byte offset (0x00 data, 0x04 status/command, 0x08 interrupt control) |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte for the selected offset |
| rs_addr | output | RS_ADDR_W | Register-space address |
| rs_wdata | output | 8 | Register-space write byte |
| rs_we | output | 1 | Register-space write enable, one cycle per write |
| rs_rdata | input | 8 | Register-space read byte for rs_addr |

## Verification
The assertions check on every cycle that a byte write raises input-full and that the flag falls exactly BUSY_CYCLES cycles after the write. They also track the command flag after writes to each port, allow register-space writes only while a data byte is being consumed, require output-full to rise only as input-full falls, clear output-full on a data-port read, and keep writes to the interrupt control byte from setting busy. Only the bench scenarios can show the values that flow end to end. These include the byte returned by a read at the address that was sent, the single write with the right address and data, the query constant, the burst bit, abandoned sequences, and stray bytes that leave the register space untouched.

// File: rtl/ec_pkg.sv
package ec_pkg;
  localparam int OFS_DATA   = 0;
  localparam int OFS_STATUS = 4;
  localparam int OFS_ICR    = 8;

  localparam logic [7:0] CMD_READ      = 8'h80;
  localparam logic [7:0] CMD_WRITE     = 8'h81;
  localparam logic [7:0] CMD_BURST_ON  = 8'h82;
  localparam logic [7:0] CMD_BURST_OFF = 8'h83;
  localparam logic [7:0] CMD_QUERY     = 8'h84;

  localparam int ST_OBF   = 0;
  localparam int ST_IBF   = 1;
  localparam int ST_SMI   = 2;
  localparam int ST_CMD   = 3;
  localparam int ST_BURST = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_RD_ADDR = 2'd1,
    SEQ_WR_ADDR = 2'd2,
    SEQ_WR_DATA = 2'd3
  } seq_t;
endpackage

// File: rtl/ec_busy_timer.sv
module ec_busy_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic consume
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy    = (cnt_q != '0);
  assign consume = (cnt_q == CNT_W'(1)) && !load;
endmodule

// File: rtl/ec_seq_engine.sv
module ec_seq_engine
  import ec_pkg::*;
#(
  parameter int         RS_ADDR_W   = 8,
  parameter logic [7:0] QUERY_VALUE = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 consume,
  input  logic                 byte_is_cmd,
  input  logic [7:0]           byte_val,
  input  logic [7:0]           rs_rdata,
  output logic [RS_ADDR_W-1:0] rs_addr,
  output logic [7:0]           rs_wdata,
  output logic                 rs_we,
  output logic                 burst,
  output logic                 ob_load,
  output logic [7:0]           ob_value
);
  seq_t                 state_q, state_d;
  logic [RS_ADDR_W-1:0] addr_q, addr_d;
  logic                 burst_q, burst_d;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    burst_d  = burst_q;
    rs_we    = 1'b0;
    ob_load  = 1'b0;
    ob_value = rs_rdata;
    if (consume) begin
      if (byte_is_cmd) begin
        state_d = SEQ_IDLE;
        case (byte_val)
          CMD_READ:      state_d = SEQ_RD_ADDR;
          CMD_WRITE:     state_d = SEQ_WR_ADDR;
          CMD_BURST_ON:  burst_d = 1'b1;
          CMD_BURST_OFF: burst_d = 1'b0;
          CMD_QUERY: begin
            ob_load  = 1'b1;
            ob_value = QUERY_VALUE;
          end
          default: ;
        endcase
      end else begin
        case (state_q)
          SEQ_RD_ADDR: begin
            ob_load = 1'b1;
            state_d = SEQ_IDLE;
          end
          SEQ_WR_ADDR: begin
            addr_d  = byte_val[RS_ADDR_W-1:0];
            state_d = SEQ_WR_DATA;
          end
          SEQ_WR_DATA: begin
            rs_we   = 1'b1;
            state_d = SEQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      burst_q <= burst_d;
    end
  end

  assign rs_addr  = (state_q == SEQ_WR_DATA) ? addr_q : byte_val[RS_ADDR_W-1:0];
  assign rs_wdata = byte_val;
  assign burst    = burst_q;
endmodule

// File: rtl/ec_out_buffer.sv
module ec_out_buffer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] value,
  input  logic       take,
  output logic       full,
  output logic [7:0] data
);
  logic       full_d;
  logic [7:0] data_d;

  always_comb begin
    full_d = full;
    data_d = data;
    if (take) full_d = 1'b0;
    if (load) begin
      full_d = 1'b1;
      data_d = value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_pkg::*;
#(
  parameter int         BUSY_CYCLES = 4,
  parameter logic [7:0] QUERY_VALUE = 8'hA5,
  parameter int         RS_ADDR_W   = 8,
  parameter int         OFS_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [OFS_W-1:0]     bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic [RS_ADDR_W-1:0] rs_addr,
  output logic [7:0]           rs_wdata,
  output logic                 rs_we,
  input  logic [7:0]           rs_rdata
);
  logic sel_data, sel_cmd, sel_icr, host_wr;
  logic [7:0] byte_q, byte_d;
  logic       cmd_flag_q, cmd_flag_d;
  logic [7:0] icr_q, icr_d;
  logic       ibf, consume, burst, ob_load, obf;
  logic [7:0] ob_value, ob_data, status;

  assign sel_data = (bus_addr == OFS_W'(OFS_DATA));
  assign sel_cmd  = (bus_addr == OFS_W'(OFS_STATUS));
  assign sel_icr  = (bus_addr == OFS_W'(OFS_ICR));
  assign host_wr  = bus_we && (sel_data || sel_cmd);

  always_comb begin
    byte_d     = byte_q;
    cmd_flag_d = cmd_flag_q;
    icr_d      = icr_q;
    if (host_wr) begin
      byte_d     = bus_wdata;
      cmd_flag_d = sel_cmd;
    end
    if (bus_we && sel_icr)
      icr_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q     <= '0;
      cmd_flag_q <= 1'b0;
      icr_q      <= '0;
    end else begin
      byte_q     <= byte_d;
      cmd_flag_q <= cmd_flag_d;
      icr_q      <= icr_d;
    end
  end

  ec_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(host_wr), .busy(ibf), .consume(consume)
  );

  ec_seq_engine #(.RS_ADDR_W(RS_ADDR_W), .QUERY_VALUE(QUERY_VALUE)) u_seq (
    .clk(clk), .rst_n(rst_n), .consume(consume), .byte_is_cmd(cmd_flag_q),
    .byte_val(byte_q), .rs_rdata(rs_rdata), .rs_addr(rs_addr),
    .rs_wdata(rs_wdata), .rs_we(rs_we), .burst(burst),
    .ob_load(ob_load), .ob_value(ob_value)
  );

  ec_out_buffer u_obuf (
    .clk(clk), .rst_n(rst_n), .load(ob_load), .value(ob_value),
    .take(bus_re && sel_data), .full(obf), .data(ob_data)
  );

  always_comb begin
    status           = '0;
    status[ST_OBF]   = obf;
    status[ST_IBF]   = ibf;
    status[ST_SMI]   = 1'b0;
    status[ST_CMD]   = cmd_flag_q;
    status[ST_BURST] = burst;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data)     bus_rdata = ob_data;
    else if (sel_cmd) bus_rdata = status;
    else if (sel_icr) bus_rdata = icr_q;
  end
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
  parameter int BUSY_CYCLES = 4,
  parameter int OFS_W       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             bus_re,
  input logic [OFS_W-1:0] bus_addr,
  input logic             rs_we,
  input logic             ibf,
  input logic             obf,
  input logic             cmd_flag
);
  localparam int SAT = BUSY_CYCLES + 2;
  localparam int CW  = $clog2(BUSY_CYCLES + 3);

  logic a_data, a_cmd, a_icr, a_wr;
  logic [CW-1:0] since_wr;

  assign a_data = (bus_addr == OFS_W'(0));
  assign a_cmd  = (bus_addr == OFS_W'(4));
  assign a_icr  = (bus_addr == OFS_W'(8));
  assign a_wr   = bus_we && (a_data || a_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_wr <= CW'(SAT);
    else if (a_wr)                   since_wr <= CW'(1);
    else if (since_wr != CW'(SAT))   since_wr <= since_wr + CW'(1);
  end

  assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |=> ibf);
  assert_ibf_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf) |-> (since_wr == CW'(BUSY_CYCLES + 1)));
  assert_cmd_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_cmd) |=> cmd_flag);
  assert_cmd_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_data) |=> !cmd_flag);
  assert_we_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_we |-> (ibf && !cmd_flag));
  assert_we_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_we && !a_wr) |=> !ibf);
  assert_obf_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf) |-> (!ibf && $past(ibf)));
  assert_obf_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && a_data && !ibf) |=> !obf);
  assert_icr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_icr && !ibf) |=> !ibf);
endmodule

bind ec_host_port ec_host_port_chk #(.BUSY_CYCLES(BUSY_CYCLES), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .rs_we(rs_we), .ibf(ibf), .obf(obf),
  .cmd_flag(cmd_flag_q)
);

// File: tb/test_ec_host_port.sv
module test_ec_host_port;
  localparam int         BUSY  = 4;
  localparam logic [7:0] QUERY = 8'hA5;

  logic clk, rst_n, bus_we, bus_re, rs_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, rs_wdata, rs_rdata, rs_addr;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int  wr_count;
  logic [7:0] last_a, last_d;
  int  nchk, nerr;
  bit  done;
  bit  m_burst;

  ec_host_port #(.BUSY_CYCLES(BUSY), .QUERY_VALUE(QUERY), .RS_ADDR_W(8), .OFS_W(4)) i_ec_host_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rs_addr(rs_addr), .rs_wdata(rs_wdata), .rs_we(rs_we), .rs_rdata(rs_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign rs_rdata = mem[rs_addr];

  always @(posedge clk) begin
    if (rst_n && rs_we) begin
      mem[rs_addr] = rs_wdata;
      wr_count = wr_count + 1;
      last_a = rs_addr;
      last_d = rs_wdata;
    end
  end

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7 + 3) ^ 8'h5C);
  endfunction

  function automatic logic [7:0] exp_status(bit obf, bit ibf, bit cmd, bit burst);
    return {3'b000, burst, cmd, 1'b0, ibf, obf};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ofs, logic [7:0] v);
    @(negedge clk);
    bus_addr = 4'(ofs); bus_wdata = v; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(int ofs, output logic [7:0] v);
    @(negedge clk);
    bus_addr = 4'(ofs); bus_re = 1'b1;
    #2 v = bus_rdata;
    @(posedge clk);
    #1 bus_re = 1'b0;
  endtask

  task automatic peek(int ofs, output logic [7:0] v);
    @(negedge clk);
    bus_addr = 4'(ofs);
    #2 v = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] s;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      peek(4, s);
      if (!s[1]) return;
      n++;
    end
    chk("R2 idle timeout", 32'(n), 32'(BUSY));
  endtask

  task automatic send(int ofs, logic [7:0] v);
    int n;
    wr(ofs, v);
    wait_idle(n);
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    int c0;
    c0 = wr_count;
    send(4, 8'h81); send(0, a); send(0, d);
    ref_mem[a] = d;
    chk("R5 one write", 32'(wr_count), 32'(c0 + 1));
    chk("R5 write addr", 32'(last_a), 32'(a));
    chk("R5 write data", 32'(last_d), 32'(d));
  endtask

  task automatic do_read(logic [7:0] a, output logic [7:0] v);
    logic [7:0] s;
    send(4, 8'h80); send(0, a);
    peek(4, s);
    chk("R4 obf set", 32'(s), 32'(exp_status(1, 0, 0, m_burst)));
    rd(0, v);
    peek(4, s);
    chk("R6 obf cleared", 32'(s[0]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s;
    int n, c0;
    nchk = 0; nerr = 0; done = 0; wr_count = 0; m_burst = 0;
    last_a = 0; last_d = 0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      ref_mem[i] = init_val(i);
    end
    bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    void'($urandom(32'h00C0FFEE));
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    peek(4, s); chk("R1 status reset", 32'(s), 32'h0);
    peek(8, s); chk("R1 icr reset", 32'(s), 32'h0);
    chk("R1 no writes", 32'(wr_count), 32'd0);

    wr(4, 8'h82); wait_idle(n);
    chk("R2 busy length", 32'(n), 32'(BUSY));
    m_burst = 1;
    peek(4, s); chk("R7 burst on, R3 cmd bit set", 32'(s), 32'(exp_status(0, 0, 1, 1)));
    send(4, 8'h83); m_burst = 0;
    peek(4, s); chk("R7 burst off", 32'(s), 32'(exp_status(0, 0, 1, 0)));
    chk("R7 no access", 32'(wr_count), 32'd0);

    do_read(8'h00, v); chk("R4 read 0x00", 32'(v), 32'(ref_mem[0]));
    peek(4, s); chk("R3 cmd bit cleared", 32'(s[3]), 32'd0);
    send(4, 8'h80); send(0, 8'hFF);
    rd(4, s); chk("R6 status read keeps obf", 32'(s[0]), 32'd1);
    rd(0, v); chk("R4 read 0xFF", 32'(v), 32'(ref_mem[255]));

    do_write(8'h10, 8'hC3);
    do_read(8'h10, v); chk("R5 readback", 32'(v), 32'h0C3);

    send(4, 8'h84);
    peek(4, s); chk("R8 query obf", 32'(s[0]), 32'd1);
    rd(0, v); chk("R8 query value", 32'(v), 32'(QUERY));

    c0 = wr_count;
    send(4, 8'h81); send(0, 8'h20);
    do_read(8'h20, v);
    chk("R9 abort write no access", 32'(wr_count), 32'(c0));
    chk("R9 read after abort", 32'(v), 32'(ref_mem[8'h20]));
    send(4, 8'h80);
    do_write(8'h31, 8'h77);
    chk("R9 abort read no obf", 32'(last_a), 32'h31);
    peek(4, s); chk("R9 obf clear after write", 32'(s[0]), 32'd0);

    c0 = wr_count;
    send(0, 8'h55);
    send(4, 8'h90); send(0, 8'h40); send(0, 8'h41);
    chk("R10 stray no writes", 32'(wr_count), 32'(c0));
    peek(4, s); chk("R10 obf unchanged", 32'(s[0]), 32'd0);

    wr(8, 8'h3C);
    peek(4, s); chk("R11 icr no busy", 32'(s[1]), 32'd0);
    chk("R11 cmd bit unchanged", 32'(s[3]), 32'd0);
    peek(8, s); chk("R11 icr readback", 32'(s), 32'h3C);

    for (int it = 0; it < 200; it++) begin
      logic [7:0] a, d;
      a = 8'($urandom); d = 8'($urandom);
      case ($urandom % 4)
        0: do_write(a, d);
        1: begin do_read(a, v); chk("R4 random read", 32'(v), 32'(ref_mem[a])); end
        2: begin send(4, 8'h84); rd(0, v); chk("R8 random query", 32'(v), 32'(QUERY)); end
        default: begin
          m_burst = !m_burst;
          send(4, m_burst ? 8'h82 : 8'h83);
          peek(4, s); chk("R7 random burst", 32'(s), 32'(exp_status(0, 0, 1, m_burst)));
        end
      endcase
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule